// File: doc/BRIEF.md
# Multi-Source Interrupt Vector Generator

This block gathers seven active-low interrupt request lines into a single interrupt request output for a processor, and answers the processor's acknowledge with an 8-bit vector for the low byte of the data bus. The request lines pass through a two-flop synchronizer. The interrupt output is raised whenever any synchronized request line is low, which is the NAND of the active-low lines.

When the acknowledge input falls, the block captures a vector and drives it, with its output enable, until the acknowledge input rises again. In raw mode the vector is the request pattern itself with bit 7 forced to one. A single request therefore yields its own unique code, and several requests yield a combined code. In priority mode only the lowest-numbered active request is kept, so the vector always equals one single-request code. With no request active, the vector is 0xFF in both modes.

Top module: `irq_vector_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising clock edge), intr is 0, vec_oe is 0 and vec_out is 0x00.
- R2: intr is 1 exactly when at least one bit of irq_n, as sampled two rising edges earlier, was 0. A change on irq_n appears on intr after the second rising edge and not after the first.
- R3: In raw mode (prio_en = 0), with one request line n low, the acknowledged vector is 0xFF with bit n cleared: IRQ0 gives 0xFE, IRQ1 0xFD, IRQ2 0xFB, IRQ3 0xF7, IRQ4 0xEF, IRQ5 0xDF, IRQ6 0xBF. Bit 7 of a driven vector is always 1.
- R4: In raw mode with several request lines low, the vector is {1, irq_n[6:0]}. For example, IRQ0 and IRQ3 give 0xF6, and all seven give 0x80.
- R5: In priority mode (prio_en = 1), only the lowest-numbered low request line is cleared in the vector. For example, IRQ0 and IRQ3 give 0xFE, and IRQ2 and IRQ5 give 0xFB. A driven vector in this mode has at most one cleared bit among bits 6..0.
- R6: With no request line low at capture, the vector is 0xFF in both modes.
- R7: vec_oe rises at the third rising edge after inta_n falls and clears at the third rising edge after inta_n rises. While vec_oe is 0, vec_out is 0x00.
- R8: While vec_oe stays 1, vec_out does not change, even if irq_n or prio_en change during the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | 7 | Interrupt requests, active low, bit n is request n |
| inta_n | input | 1 | Processor acknowledge, active low |
| prio_en | input | 1 | 0 = raw vector, 1 = lowest-numbered request only |
| intr | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector for the data bus low byte, 0x00 when not enabled |
| vec_oe | output | 1 | Enable for the external bus driver, 1 during acknowledge |

## Verification
On every cycle, the assertions check the two-edge latency from the request lines to intr, the quiet bus while the enable is low, and the rise of the enable only after a held acknowledge. They also check that bit 7 of a driven vector is one, that the driven byte is stable, and that a priority-mode vector has at most one cleared bit. Only the bench's scenarios can show the exact byte each request pattern gives in each mode, the 0xFF code with no request, and the exact edges at which the enable rises and falls.

// File: rtl/irqv_pkg.sv
// Package: shared mode encoding and default sizes for the interrupt vector generator.
// Assumes: nothing beyond IEEE 1800-2017.
package irqv_pkg;

    // Vector build mode selected by the priority-enable input.
    typedef enum logic {
        VEC_RAW  = 1'b0,
        VEC_PRIO = 1'b1
    } vec_mode_e;

    localparam int unsigned DEF_NUM_REQ     = 7;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/irqv_sync.sv
// Module: multi-stage flop synchronizer for a bus of independent asynchronous bits.
// Assumes: each bit is treated separately (no bus coherence); reset loads RST_VAL,
// which for active-low lines is the idle level.
module irqv_sync #(
    parameter int unsigned      W      = 7,
    parameter int unsigned      STAGES = 2,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_async;
    end

    // Remaining stages shift the sample towards the output.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/irqv_encode.sv
// Module: builds the acknowledge vector from synchronized active-low requests.
// Raw mode: {1, req_n}. Priority mode: only the lowest-numbered active request is
// cleared. Assumes: req_n is already synchronous to the clock.
module irqv_encode
    import irqv_pkg::*;
#(
    parameter int unsigned NUM_REQ = 7,
    localparam int unsigned VEC_W  = NUM_REQ + 1
) (
    input  logic [NUM_REQ-1:0] req_n,
    input  vec_mode_e          mode,
    output logic [VEC_W-1:0]   vec
);

    logic [NUM_REQ-1:0] active;
    logic [NUM_REQ-1:0] lowest;

    // Isolate the lowest set bit of the active-high request set.
    always_comb begin
        active = ~req_n;
        lowest = active & (~active + NUM_REQ'(1));
    end

    // Select the vector according to the mode.
    always_comb begin
        if (mode == VEC_PRIO) vec = {1'b1, ~lowest};
        else                  vec = {1'b1, req_n};
    end

endmodule

// File: rtl/irqv_ack_ctrl.sv
// Module: acknowledge handshake. Captures the vector on a falling synchronized
// acknowledge and enables the bus until the acknowledge returns high.
// Assumes: inta_s is synchronized; vec_in is valid in the capture cycle.
module irqv_ack_ctrl #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inta_s,
    input  logic [VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0] vec_q,
    output logic             oe
);

    logic inta_d;
    logic fall;

    // Delayed copy of the acknowledge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) inta_d <= 1'b1;
        else        inta_d <= inta_s;
    end

    // Falling edge of the synchronized acknowledge.
    assign fall = inta_d & ~inta_s;

    // Capture the vector once per acknowledge and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_q <= '0;
        else if (fall) vec_q <= vec_in;
    end

    // Bus enable set at capture, cleared once the acknowledge is released.
    always_ff @(posedge clk) begin
        if (!rst_n)      oe <= 1'b0;
        else if (fall)   oe <= 1'b1;
        else if (inta_s) oe <= 1'b0;
    end

endmodule

// File: rtl/irq_vector_gen.sv
// Module: top of the multi-source interrupt vector generator.
// Combines active-low requests into one interrupt output and answers the
// acknowledge with a vector byte plus an output enable for an external bus driver.
// Assumes: irq_n and inta_n are asynchronous; clk is faster than the handshake.
module irq_vector_gen
    import irqv_pkg::*;
#(
    parameter int unsigned NUM_REQ     = DEF_NUM_REQ,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int unsigned VEC_W      = NUM_REQ + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] irq_n,
    input  logic               inta_n,
    input  logic               prio_en,
    output logic               intr,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_oe
);

    logic [NUM_REQ-1:0] irq_s;
    logic               inta_s;
    logic [VEC_W-1:0]   vec_next;
    logic [VEC_W-1:0]   vec_q;
    vec_mode_e          mode;

    irqv_sync #(.W(NUM_REQ), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_n),
        .q_sync  (irq_s)
    );

    irqv_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (inta_n),
        .q_sync  (inta_s)
    );

    // Mode decode from the priority-enable pin.
    assign mode = prio_en ? VEC_PRIO : VEC_RAW;

    irqv_encode #(.NUM_REQ(NUM_REQ)) i_encode (
        .req_n (irq_s),
        .mode  (mode),
        .vec   (vec_next)
    );

    irqv_ack_ctrl #(.VEC_W(VEC_W)) i_ack (
        .clk    (clk),
        .rst_n  (rst_n),
        .inta_s (inta_s),
        .vec_in (vec_next),
        .vec_q  (vec_q),
        .oe     (vec_oe)
    );

    // Interrupt request: NAND of the synchronized active-low lines.
    assign intr    = ~&irq_s;
    // Bus value is quiet while the driver is disabled.
    assign vec_out = vec_oe ? vec_q : '0;

endmodule

// File: rtl/irqv_checker.sv
// Module: assertion checker for irq_vector_gen, attached with bind.
// Assumes: the default two-stage synchronizer (latencies below are written for it).
module irqv_checker #(
    parameter int unsigned NUM_REQ = 7,
    localparam int unsigned VEC_W  = NUM_REQ + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] irq_n,
    input logic               inta_n,
    input logic               prio_en,
    input logic               intr,
    input logic [VEC_W-1:0]   vec_out,
    input logic               vec_oe
);

    logic       rst_q;
    logic [1:0] since_rst;

    // Previous reset level, for the reset-release check.
    always_ff @(posedge clk) rst_q <= rst_n;

    // Saturating count of edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: state just after reset.
    always_ff @(posedge clk) begin
        if (rst_n && !rst_q) begin
            a_r1_reset_state: assert (!vec_oe && !intr && vec_out == '0)
                else $error("R1 reset state wrong");
        end
    end

    a_r2_intr_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (intr == ~&$past(irq_n, 2)));

    a_r3_bit7_high: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> vec_out[VEC_W-1]);

    a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_oe) && $past(prio_en)) |-> ($countones(~vec_out[VEC_W-2:0]) <= 1));

    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_out == '0));

    a_r7_oe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && !$past(vec_oe)) |-> !$past(inta_n, 2));

    a_r8_stable_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_out));

endmodule

bind irq_vector_gen irqv_checker #(.NUM_REQ(NUM_REQ)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_n   (irq_n),
    .inta_n  (inta_n),
    .prio_en (prio_en),
    .intr    (intr),
    .vec_out (vec_out),
    .vec_oe  (vec_oe)
);

// File: tb/test_irq_vector_gen.sv
// Directed bench for irq_vector_gen: one task per scenario, each checks itself.
module test_irq_vector_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] irq_n;
    logic       inta_n;
    logic       prio_en;
    logic       intr;
    logic [7:0] vec_out;
    logic       vec_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_gen i_irq_vector_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n   (irq_n),
        .inta_n  (inta_n),
        .prio_en (prio_en),
        .intr    (intr),
        .vec_out (vec_out),
        .vec_oe  (vec_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Expected vector in priority mode: keep only lowest low line.
    function automatic logic [7:0] prio_vec(input logic [6:0] pat);
        logic [7:0] v = 8'hFF;
        for (int i = 0; i < 7; i++) begin
            if (!pat[i]) begin
                v[i] = 1'b0;
                break;
            end
        end
        return v;
    endfunction

    // Full acknowledge: request pattern settles, ack, check, release, check quiet.
    task automatic ack_cycle(input string req, input logic [6:0] pat,
                             input logic prio, input logic [7:0] exp);
        irq_n   = pat;
        prio_en = prio;
        tick(3);
        inta_n = 1'b0;
        tick(4);
        check(req, {7'd0, vec_oe}, 8'd1);
        check(req, vec_out, exp);
        inta_n = 1'b1;
        tick(4);
        check("R7", {7'd0, vec_oe}, 8'd0);
        check("R7", vec_out, 8'h00);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; irq_n = '1; inta_n = 1'b1; prio_en = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1", {7'd0, intr}, 8'd0);
        check("R1", {7'd0, vec_oe}, 8'd0);
        check("R1", vec_out, 8'h00);
    endtask

    task automatic t_intr_latency;
        irq_n = 7'b111_0111;
        tick(1);
        check("R2", {7'd0, intr}, 8'd0);
        tick(1);
        check("R2", {7'd0, intr}, 8'd1);
        irq_n = '1;
        tick(1);
        check("R2", {7'd0, intr}, 8'd1);
        tick(1);
        check("R2", {7'd0, intr}, 8'd0);
    endtask

    task automatic t_single_raw;
        for (int i = 0; i < 7; i++) begin
            logic [6:0] pat = 7'h7F;
            pat[i] = 1'b0;
            ack_cycle("R3", pat, 1'b0, {1'b1, pat});
        end
        check("R3", 8'hBF, {1'b1, 7'b011_1111});
    endtask

    task automatic t_multi_raw;
        ack_cycle("R4", 7'b111_0110, 1'b0, 8'hF6);
        ack_cycle("R4", 7'b011_1101, 1'b0, 8'hBD);
        ack_cycle("R4", 7'b000_0000, 1'b0, 8'h80);
    endtask

    task automatic t_priority;
        ack_cycle("R5", 7'b111_0110, 1'b1, 8'hFE);
        ack_cycle("R5", 7'b101_1011, 1'b1, 8'hFB);
        ack_cycle("R5", 7'b000_0000, 1'b1, prio_vec(7'b000_0000));
        ack_cycle("R5", 7'b011_1111, 1'b1, 8'hBF);
        ack_cycle("R5", 7'b010_1000, 1'b1, prio_vec(7'b010_1000));
    endtask

    task automatic t_none;
        ack_cycle("R6", 7'h7F, 1'b0, 8'hFF);
        ack_cycle("R6", 7'h7F, 1'b1, 8'hFF);
        check("R6", {7'd0, intr}, 8'd0);
    endtask

    task automatic t_oe_timing;
        irq_n = 7'b110_1111; prio_en = 1'b0;
        tick(3);
        inta_n = 1'b0;
        tick(2);
        check("R7", {7'd0, vec_oe}, 8'd0);
        check("R7", vec_out, 8'h00);
        tick(1);
        check("R7", {7'd0, vec_oe}, 8'd1);
        check("R7", vec_out, 8'hEF);
        inta_n = 1'b1;
        tick(2);
        check("R7", {7'd0, vec_oe}, 8'd1);
        tick(1);
        check("R7", {7'd0, vec_oe}, 8'd0);
        check("R7", vec_out, 8'h00);
    endtask

    task automatic t_hold;
        irq_n = 7'b111_1011; prio_en = 1'b0;
        tick(3);
        inta_n = 1'b0;
        tick(4);
        check("R8", vec_out, 8'hFB);
        irq_n = 7'b000_0000; prio_en = 1'b1;
        tick(4);
        check("R8", vec_out, 8'hFB);
        irq_n = 7'b111_1110;
        tick(4);
        check("R8", vec_out, 8'hFB);
        check("R8", {7'd0, vec_oe}, 8'd1);
        inta_n = 1'b1;
        tick(4);
        irq_n = '1;
        tick(3);
    endtask

    initial begin
        t_reset();
        t_intr_latency();
        t_single_raw();
        t_multi_raw();
        t_priority();
        t_none();
        t_oe_timing();
        t_hold();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule